// File: doc/BRIEF.md
# Parity-Gated Pattern Rotator Bank

The block holds a bank of eight small rotating registers, one lane per 128-bit round-key input. All lanes share one 128-bit state word. On every rising clock edge each lane computes its own enable: the low byte of the state is ANDed bit by bit with the low byte of that lane's key, and the eight result bits are XOR-reduced to a single parity bit. When the parity is one, the lane rotates its 8-bit register left by one place, with bit 7 wrapping into bit 0. When the parity is zero, the lane holds its value.

Each lane starts from an alternating bit pattern, so a rotation always flips the lane between two values. Every lane therefore toggles between 0xAA and 0x55 at a rate set by its own key. No trigger input exists. The bank runs on every cycle in which reset is low. Producing the round keys is left to the surrounding logic.

Top module: `parity_rotor_bank`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) loads every lane with 0xAA, meaning bit i is one exactly when i is odd.
- R2: The enable of lane n is the odd parity of the eight bits of (state_i[7:0] AND rkey_i[n][7:0]), i.e. one when an odd number of those bits are set.
- R3: At a rising edge with the lane enable high and reset low, the lane value becomes its previous value rotated left by one place, with bit 7 moving into bit 0.
- R4: At a rising edge with the lane enable low and reset low, the lane value is unchanged.
- R5: Each lane depends only on the shared state and its own key, so a key change on one lane never alters another lane's value.
- R6: Bits 127:8 of state_i and of every key have no effect on any lane.
- R7: There is no trigger. A lane whose enable is high rotates on the first rising edge after reset is released.
- R8: After reset every lane only ever holds 0xAA or 0x55, and a lane whose enable stays high alternates between them on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| state_i | input | 128 | Shared state word; only bits 7:0 are used |
| rkey_i | input | 8x128 | One round-key word per lane, packed with lane n at index n |
| lane_o | output | 8x8 | Register value of each lane, lane n at index n |

## Verification
The bench sweeps all 256 values of the low state byte. For each value it gives each lane a key byte from a separate arithmetic sequence, so the set of enabled lanes changes from one cycle to the next. It also fills the upper 120 bits of every word with changing junk. This tells apart a correct parity gate from gates that use only part of the byte, that OR instead of AND, or that let upper bits through. Fixed cases pin one lane to a key that keeps it enabled and one to a zero key. These separate rotation direction and every-cycle alternation from holding. A reset in the middle of the run, followed by an immediately enabled lane, shows that the reset value is reloaded and that no arming cycle is needed.

// File: rtl/rotor_bank_pkg.sv
package rotor_bank_pkg;

    parameter int unsigned LANES_DEF  = 8;
    parameter int unsigned LANE_W_DEF = 8;
    parameter int unsigned WORD_W_DEF = 128;
    parameter int unsigned TAP_W_DEF  = 8;

    // Alternating pattern: bit i set for odd i (0xAA for an 8-bit lane).
    function automatic logic [63:0] alt_pattern(input int unsigned width);
        logic [63:0] p;
        p = '0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < width) p[i] = i[0];
        end
        return p;
    endfunction

endpackage

// File: rtl/lane_parity_gate.sv
module lane_parity_gate #(
    parameter int unsigned WORD_W = rotor_bank_pkg::WORD_W_DEF,
    parameter int unsigned TAP_W  = rotor_bank_pkg::TAP_W_DEF
) (
    input  logic [WORD_W-1:0] state_i,
    input  logic [WORD_W-1:0] key_i,
    output logic              en_o
);
    localparam logic [WORD_W-1:0] TAP_MASK = {{(WORD_W-TAP_W){1'b0}}, {TAP_W{1'b1}}};

    logic [WORD_W-1:0] masked_and;

    always_comb begin
        masked_and = state_i & key_i & TAP_MASK;
        en_o       = ^masked_and;
    end
endmodule

// File: rtl/lane_rotor_cell.sv
module lane_rotor_cell #(
    parameter int unsigned LANE_W = rotor_bank_pkg::LANE_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    output logic [LANE_W-1:0] val_o
);
    localparam logic [63:0]       PAT_FULL = rotor_bank_pkg::alt_pattern(LANE_W);
    localparam logic [LANE_W-1:0] RST_PAT  = PAT_FULL[LANE_W-1:0];
    localparam logic [LANE_W-1:0] ALT_PAT  = ~RST_PAT;

    typedef struct packed {
        logic [LANE_W-1:0] pat;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.pat = RST_PAT;
        end else if (en_i) begin
            st_d.pat = {st_q.pat[LANE_W-2:0], st_q.pat[LANE_W-1]};
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign val_o = st_q.pat;

    // R1
    reset_load_chk: assert property (@(posedge clk_i)
        rst_i |=> (val_o == RST_PAT));

    // R3
    rotate_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (val_o == {$past(val_o[LANE_W-2:0]), $past(val_o[LANE_W-1])}));

    // R4
    hold_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(val_o));

    // R8
    two_values_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> ((val_o == RST_PAT) || (val_o == ALT_PAT)));
endmodule

// File: rtl/parity_rotor_bank.sv
module parity_rotor_bank #(
    parameter int unsigned LANES  = rotor_bank_pkg::LANES_DEF,
    parameter int unsigned LANE_W = rotor_bank_pkg::LANE_W_DEF,
    parameter int unsigned WORD_W = rotor_bank_pkg::WORD_W_DEF,
    parameter int unsigned TAP_W  = rotor_bank_pkg::TAP_W_DEF
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [WORD_W-1:0]             state_i,
    input  logic [LANES-1:0][WORD_W-1:0]  rkey_i,
    output logic [LANES-1:0][LANE_W-1:0]  lane_o
);
    logic [LANES-1:0] lane_en;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        lane_parity_gate #(
            .WORD_W (WORD_W),
            .TAP_W  (TAP_W)
        ) gate_i (
            .state_i (state_i),
            .key_i   (rkey_i[n]),
            .en_o    (lane_en[n])
        );

        lane_rotor_cell #(
            .LANE_W (LANE_W)
        ) cell_i (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .en_i  (lane_en[n]),
            .val_o (lane_o[n])
        );

        // R5 R2: with its own gate quiet, a lane is unaffected by the others
        lane_isolation_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !lane_en[n] |=> $stable(lane_o[n]));
    end
endmodule

// File: tb/parity_rotor_bank_tb_top.sv
`timescale 1ns/1ps
module parity_rotor_bank_tb_top;
    localparam int LANES = 8;
    localparam int LW    = 8;
    localparam int WW    = 128;

    logic clk = 1'b0;
    logic rst;
    logic [WW-1:0]            state;
    logic [LANES-1:0][WW-1:0] rkey;
    logic [LANES-1:0][LW-1:0] lane;

    int checks = 0;
    int fails  = 0;
    logic [LW-1:0] expv [LANES];

    always #4 clk = ~clk;

    parity_rotor_bank dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .state_i (state),
        .rkey_i  (rkey),
        .lane_o  (lane)
    );

    task automatic chk(input string req, input int n, input logic [LW-1:0] got, input logic [LW-1:0] ex);
        checks++;
        if (got !== ex) begin
            fails++;
            $display("FAIL %s lane %0d: got %h expected %h", req, n, got, ex);
        end
    endtask

    function automatic bit parity_of(input logic [7:0] s, input logic [7:0] k);
        int c;
        c = 0;
        for (int b = 0; b < 8; b++) if (s[b] && k[b]) c++;
        return (c % 2) == 1;
    endfunction

    // model update: enabled lanes swap 0xAA <-> 0x55 (one left rotation of either)
    task automatic advance_model();
        for (int n = 0; n < LANES; n++)
            if (parity_of(state[7:0], rkey[n][7:0]))
                expv[n] = (expv[n] == 8'hAA) ? 8'h55 : 8'hAA;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        for (int n = 0; n < LANES; n++) begin
            expv[n] = 8'hAA;
            chk("R1", n, lane[n], 8'hAA);
        end
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst   = 1'b1;
        state = '0;
        rkey  = '0;
        do_reset();

        // R7 R8: lane 0 enabled every cycle from the first cycle, lane 1 key zero holds (R4)
        state = {120'h0, 8'h01};
        for (int n = 0; n < LANES; n++) rkey[n] = '0;
        rkey[0] = {120'h0, 8'h01};
        for (int c = 0; c < 6; c++) begin
            tick();
            chk("R7/R8", 0, lane[0], (c % 2 == 0) ? 8'h55 : 8'hAA);
            chk("R4", 1, lane[1], 8'hAA);
        end

        // R6: upper bits toggle freely while low-byte parity stays zero
        do_reset();
        for (int c = 0; c < 8; c++) begin
            state = {{15{8'hFF}} ^ {15{c[7:0]}}, 8'h0F};
            for (int n = 0; n < LANES; n++) rkey[n] = {{15{8'h5A}} ^ {15{n[7:0] + c[7:0]}}, 8'hF0};
            tick();
            for (int n = 0; n < LANES; n++) chk("R6", n, lane[n], 8'hAA);
        end

        // R2 R3 R4 R5: sweep every low state byte, varied key per lane, junk upper bits
        do_reset();
        for (int s = 0; s < 256; s++) begin
            state = {{15{s[7:0] ^ 8'h3C}}, s[7:0]};
            for (int n = 0; n < LANES; n++) begin
                logic [7:0] kb;
                kb = 8'(n * 37 + s * 11 + (s >> 3));
                rkey[n] = {{15{kb ^ 8'hC3}}, kb};
            end
            advance_model();
            tick();
            for (int n = 0; n < LANES; n++) chk("R2/R3/R4/R5", n, lane[n], expv[n]);
        end

        // R5: only lane 3 key changes; others held at zero must not move
        state = {120'h0, 8'hFF};
        for (int n = 0; n < LANES; n++) rkey[n] = '0;
        for (int c = 0; c < 4; c++) begin
            rkey[3] = {120'h0, 8'(1 << c)};
            advance_model();
            tick();
            for (int n = 0; n < LANES; n++) chk("R5", n, lane[n], expv[n]);
        end

        // R1 R7: mid-run reset reloads, then immediate rotation
        do_reset();
        rkey[3] = {120'h0, 8'h80};
        state   = {120'h0, 8'h80};
        tick();
        chk("R7", 3, lane[3], 8'h55);
        chk("R4", 2, lane[2], 8'hAA);

        finish_run();
    end
endmodule